// File: doc/BRIEF.md
# Codec Sleep and Wake Controller

This block holds the low-power state of an audio codec's digital control section. Three power-down control words are held in registers and written through a simple strobe, select and data interface. One bit of the main word is the sleep control. While that bit is set, the serial audio link interface is switched off and a sleep flag is raised.

The sleep bit is cleared by hardware when any wake source fires. There are three kinds of wake source:
- a warm-reset pulse from the serial link;
- a rising edge on a GPIO pin that is configured as an input and has its wake enable set;
- a virtual event flag, such as a battery alarm.

A separate standby flag is raised when the codec has powered down everything it can. That is the case when every bit of the three power-down words is set, with one exempt bit whose state is ignored.

The block also forms the chip's internal reset from two active-low inputs: a supply-good monitor and an external reset pin. Reset is asserted while either input is low. The registered reset then clears all state in the block.

Top module: `codec_sleep_ctrl`

## Requirements
- R1: Sleep control is bit 12 of the main power-down word (select 0). `sleep_o` equals that bit, and `link_en_o` is always its inverse, so the link is disabled exactly while sleep is set.
- R2: A one-cycle `warm_rst_i` pulse sampled while asleep clears sleep on that same clock edge.
- R3: A GPIO pin whose `gpio_is_in_i` and `gpio_wake_en_i` bits are both 1 wakes the block on a low-to-high transition. The pin passes through two synchroniser flops and an edge register, so sleep is still set after two clock edges and is clear after the third edge following the change.
- R4: A GPIO rising edge has no effect on sleep when that pin's `gpio_is_in_i` or `gpio_wake_en_i` bit is 0.
- R5: Any bit of `virt_evt_i` sampled high while asleep clears sleep on that clock edge.
- R6: `int_rst_o` is the registered value of NOT(`por_n_i` AND `ext_rst_n_i`). It goes high one edge after either input is low, and comes up high from power-on.
- R7: While `int_rst_o` is high, every power-down bit is cleared on each clock edge. As a result, sleep and standby read 0 and `link_en_o` reads 1.
- R8: `standby_o` is 1 exactly when all bits of words 0 and 2 are set, and all bits of word 1 other than bit 14 are set. Bit 14 of word 1 does not matter. The flag updates on the same edge as the write that causes the change.
- R9: When a wake source fires while asleep, and the main word is written with its sleep bit set in the same cycle, the wake wins and sleep is cleared.
- R10: A write with select value 3 changes no power-down word, so `standby_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n_i | input | 1 | Supply-good indication, low while supplies are below threshold |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wr_en_i | input | 1 | Write strobe for a power-down word |
| wr_sel_i | input | 2 | Word select: 0 main, 1 aux A, 2 aux B, 3 none |
| wr_data_i | input | 16 | Write data |
| warm_rst_i | input | 1 | Warm-reset pulse from the serial link, synchronous |
| gpio_i | input | GPIO_N | GPIO pin levels, asynchronous |
| gpio_is_in_i | input | GPIO_N | Per-pin input configuration |
| gpio_wake_en_i | input | GPIO_N | Per-pin wake enable |
| virt_evt_i | input | VIRT_N | Virtual event flags, synchronous |
| link_en_o | output | 1 | Serial link interface enable |
| sleep_o | output | 1 | Sleep status |
| standby_o | output | 1 | Low-power standby status |
| int_rst_o | output | 1 | Combined internal reset, active high |

## Verification
Every GPIO pin is tried with all four combinations of input configuration and wake enable. This separates the single combination that wakes the block from the three that must not. Sleep is sampled after two edges and again after three, which pins down the synchroniser depth.

The standby detector is swept by clearing each of the 48 power-down bits in turn from an all-ones state. Only the exempt bit keeps the flag set, so a wrong mask position or a missing word shows up. Each reset input combination is applied while asleep, which separates the AND behaviour from a single-input reset. A write that coincides with a wake checks the priority between the two.

// File: rtl/codec_sleep_pkg.sv
package codec_sleep_pkg;
  typedef enum logic [1:0] {
    SEL_MAIN  = 2'd0,
    SEL_AUX_A = 2'd1,
    SEL_AUX_B = 2'd2,
    SEL_NONE  = 2'd3
  } pd_sel_e;

  localparam int PD_WORDS = 3;
endpackage

// File: rtl/codec_wake_detect.sv
module codec_wake_detect #(
  parameter int GPIO_N = 3,
  parameter int VIRT_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GPIO_N-1:0] gpio_i,
  input  logic [GPIO_N-1:0] gpio_is_in_i,
  input  logic [GPIO_N-1:0] gpio_wake_en_i,
  input  logic              warm_rst_i,
  input  logic [VIRT_N-1:0] virt_evt_i,
  output logic              wake_o
);
  logic [GPIO_N-1:0] sync1_q, sync2_q, prev_q;
  logic [GPIO_N-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= gpio_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // Per-pin qualified edge: only input pins with wake enabled count
  for (genvar g = 0; g < GPIO_N; g++) begin : g_pin
    assign rise[g] = sync2_q[g] & ~prev_q[g] & gpio_is_in_i[g] & gpio_wake_en_i[g];
  end

  assign wake_o = warm_rst_i | (|virt_evt_i) | (|rise);
endmodule

// File: rtl/codec_pd_regs.sv
module codec_pd_regs
  import codec_sleep_pkg::*;
#(
  parameter int W          = 16,
  parameter int SLEEP_BIT  = 12,
  parameter int EXEMPT_BIT = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         wake_i,
  output logic         sleep_o,
  output logic         link_en_o,
  output logic         standby_o
);
  localparam logic [W-1:0] EXEMPT_MASK = W'(1) << EXEMPT_BIT;

  logic [W-1:0] pd_q [PD_WORDS];
  logic [W-1:0] pd_d [PD_WORDS];
  logic         standby_d;
  logic         link_en_q, standby_q;

  always_comb begin
    for (int i = 0; i < PD_WORDS; i++) begin
      pd_d[i] = (wr_en_i && wr_sel_i == 2'(i)) ? wr_data_i : pd_q[i];
    end
    // Wake while asleep overrides any same-cycle write of the sleep bit
    if (pd_q[SEL_MAIN][SLEEP_BIT] && wake_i) begin
      pd_d[SEL_MAIN][SLEEP_BIT] = 1'b0;
    end
    standby_d = (&pd_d[SEL_MAIN]) & (&pd_d[SEL_AUX_B]) & (&(pd_d[SEL_AUX_A] | EXEMPT_MASK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PD_WORDS; i++) pd_q[i] <= '0;
      link_en_q <= 1'b1;
      standby_q <= 1'b0;
    end else begin
      for (int i = 0; i < PD_WORDS; i++) pd_q[i] <= pd_d[i];
      link_en_q <= ~pd_d[SEL_MAIN][SLEEP_BIT];
      standby_q <= standby_d;
    end
  end

  assign sleep_o   = pd_q[SEL_MAIN][SLEEP_BIT];
  assign link_en_o = link_en_q;
  assign standby_o = standby_q;
endmodule

// File: rtl/codec_sleep_ctrl.sv
module codec_sleep_ctrl #(
  parameter int W          = 16,
  parameter int SLEEP_BIT  = 12,
  parameter int EXEMPT_BIT = 14,
  parameter int GPIO_N     = 3,
  parameter int VIRT_N     = 2
) (
  input  logic              clk,
  input  logic              por_n_i,
  input  logic              ext_rst_n_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              warm_rst_i,
  input  logic [GPIO_N-1:0] gpio_i,
  input  logic [GPIO_N-1:0] gpio_is_in_i,
  input  logic [GPIO_N-1:0] gpio_wake_en_i,
  input  logic [VIRT_N-1:0] virt_evt_i,
  output logic              link_en_o,
  output logic              sleep_o,
  output logic              standby_o,
  output logic              int_rst_o
);
  logic rst_q = 1'b1;
  logic wake;

  always_ff @(posedge clk) begin
    rst_q <= ~(por_n_i & ext_rst_n_i);
  end
  assign int_rst_o = rst_q;

  codec_wake_detect #(.GPIO_N(GPIO_N), .VIRT_N(VIRT_N)) wake_i (
    .clk            (clk),
    .rst            (rst_q),
    .gpio_i         (gpio_i),
    .gpio_is_in_i   (gpio_is_in_i),
    .gpio_wake_en_i (gpio_wake_en_i),
    .warm_rst_i     (warm_rst_i),
    .virt_evt_i     (virt_evt_i),
    .wake_o         (wake)
  );

  codec_pd_regs #(.W(W), .SLEEP_BIT(SLEEP_BIT), .EXEMPT_BIT(EXEMPT_BIT)) regs_i (
    .clk       (clk),
    .rst       (rst_q),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .wake_i    (wake),
    .sleep_o   (sleep_o),
    .link_en_o (link_en_o),
    .standby_o (standby_o)
  );
endmodule

// File: rtl/codec_sleep_ctrl_chk.sv
module codec_sleep_ctrl_chk #(
  parameter int VIRT_N = 2
) (
  input logic              clk,
  input logic              int_rst,
  input logic              por_n,
  input logic              ext_rst_n,
  input logic              warm,
  input logic [VIRT_N-1:0] virt,
  input logic              sleep,
  input logic              link_en,
  input logic              standby
);
  p_link_inverse_r1: assert property (@(posedge clk) disable iff (int_rst)
    link_en == !sleep);

  p_warm_wakes_r2: assert property (@(posedge clk) disable iff (int_rst)
    (sleep && warm) |=> !sleep);

  p_virt_wakes_r5: assert property (@(posedge clk) disable iff (int_rst)
    (sleep && (|virt)) |=> !sleep);

  p_rst_assert_r6: assert property (@(posedge clk)
    (!por_n || !ext_rst_n) |=> int_rst);

  p_rst_release_r6: assert property (@(posedge clk)
    (por_n && ext_rst_n) |=> !int_rst);

  p_rst_clears_r7: assert property (@(posedge clk)
    int_rst |=> (!sleep && !standby && link_en));

  p_standby_needs_sleep_r8: assert property (@(posedge clk) disable iff (int_rst)
    standby |-> sleep);
endmodule

bind codec_sleep_ctrl codec_sleep_ctrl_chk #(.VIRT_N(VIRT_N)) chk_i (
  .clk       (clk),
  .int_rst   (int_rst_o),
  .por_n     (por_n_i),
  .ext_rst_n (ext_rst_n_i),
  .warm      (warm_rst_i),
  .virt      (virt_evt_i),
  .sleep     (sleep_o),
  .link_en   (link_en_o),
  .standby   (standby_o)
);

// File: tb/codec_sleep_ctrl_tb.sv
module codec_sleep_ctrl_tb_top;
  localparam int W = 16, GN = 3, VN = 2, SB = 12, EB = 14;

  logic clk = 1'b0;
  logic por_n, ext_rst_n, wr_en, warm;
  logic [1:0] wr_sel;
  logic [W-1:0] wr_data;
  logic [GN-1:0] gpio, is_in, wen;
  logic [VN-1:0] virt;
  logic link_en, sleep, standby, int_rst;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  codec_sleep_ctrl #(.W(W), .SLEEP_BIT(SB), .EXEMPT_BIT(EB), .GPIO_N(GN), .VIRT_N(VN)) dut_i (
    .clk(clk), .por_n_i(por_n), .ext_rst_n_i(ext_rst_n), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .warm_rst_i(warm), .gpio_i(gpio),
    .gpio_is_in_i(is_in), .gpio_wake_en_i(wen), .virt_evt_i(virt),
    .link_en_o(link_en), .sleep_o(sleep), .standby_o(standby), .int_rst_o(int_rst));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic go_sleep();
    wr(2'd0, W'(1) << SB);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    warm = 1'b0; gpio = '0; is_in = '0; wen = '0; virt = '0;
    repeat (3) @(negedge clk);
    chk("R6 power-on reset", int_rst, 1'b1);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 reset released", int_rst, 1'b0);
    chk("R7 reset sleep", sleep, 1'b0);
    chk("R7 reset link", link_en, 1'b1);
    chk("R7 reset standby", standby, 1'b0);

    // R1 sleep bit drives link enable
    go_sleep();
    chk("R1 sleep set", sleep, 1'b1);
    chk("R1 link off", link_en, 1'b0);
    wr(2'd0, '0);
    chk("R1 sleep cleared by write", sleep, 1'b0);
    chk("R1 link on", link_en, 1'b1);

    // R2 warm reset wake
    go_sleep();
    warm = 1'b1; @(negedge clk); warm = 1'b0;
    chk("R2 warm wake", sleep, 1'b0);
    chk("R2 link back", link_en, 1'b1);

    // R5 each virtual event
    for (int v = 0; v < VN; v++) begin
      go_sleep();
      virt[v] = 1'b1; @(negedge clk); virt = '0;
      chk("R5 virtual wake", sleep, 1'b0);
    end

    // R3 / R4 every pin, every configuration
    for (int p = 0; p < GN; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic exp_wake;
        exp_wake = (c == 3);
        go_sleep();
        is_in = '0; wen = '0;
        is_in[p] = c[0]; wen[p] = c[1];
        gpio[p] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 sync latency", sleep, 1'b1);
        @(negedge clk);
        if (exp_wake) chk("R3 gpio wake", sleep, 1'b0);
        else          chk("R4 gpio ignored", sleep, 1'b1);
        gpio = '0;
        repeat (4) @(negedge clk);
        is_in = '0; wen = '0;
      end
    end

    // R9 wake beats same-cycle sleep write
    go_sleep();
    @(negedge clk);
    warm = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = W'(1) << SB;
    @(negedge clk);
    warm = 1'b0; wr_en = 1'b0;
    chk("R9 wake wins", sleep, 1'b0);

    // R8 standby sweep over all 48 bits
    for (int b = 0; b < 3 * W; b++) begin
      for (int s = 0; s < 3; s++) wr(2'(s), '1);
      wr(2'(b / W), ~(W'(1) << (b % W)));
      chk("R8 standby bit sweep", standby, (b == W + EB));
    end
    for (int s = 0; s < 3; s++) wr(2'(s), '1);
    chk("R8 standby all set", standby, 1'b1);
    chk("R8 standby implies sleep", sleep, 1'b1);

    // R10 select 3 ignored
    wr(2'd3, '0);
    chk("R10 select 3 ignored", standby, 1'b1);

    // wake out of standby drops it
    virt[0] = 1'b1; @(negedge clk); virt = '0;
    chk("R8 standby left on wake", standby, 1'b0);
    chk("R5 wake from standby", sleep, 1'b0);

    // R6 / R7 reset input combinations while asleep
    for (int c = 0; c < 4; c++) begin
      logic in_rst;
      in_rst = (c != 3);
      go_sleep();
      por_n = c[0]; ext_rst_n = c[1];
      @(negedge clk);
      chk("R6 combined reset", int_rst, in_rst);
      por_n = 1'b1; ext_rst_n = 1'b1;
      @(negedge clk);
      chk("R7 sleep after reset", sleep, !in_rst);
      chk("R6 reset deasserts", int_rst, 1'b0);
      wr(2'd0, '0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule